// File: doc/BRIEF.md
# PRBS-11 Bit Error Rate Monitor

This block watches a demodulated bit stream while the far end transmits the 2047-bit maximal-length sequence built on x^11 + x^9 + 1. It locks onto that sequence by itself, with no frame marker and no known starting phase. It then runs a local copy of the generator and compares every received bit against it. Mistakes are tallied over fixed-length windows, and the total of the last complete window stays on an output until the next window finishes.

Input arrives as one strobe per symbol. In single-bit mode, each strobe carries one bit. In two-bit mode, each strobe carries one quadrature symbol made of two bits. A receiver that locks onto the carrier can leave the stream inverted, or in two-bit mode rotated by a multiple of a quarter turn. The monitor tries each possible rotation in a fixed order and keeps the first one that yields a clean run. It reports the rotation it settled on, so a change in the reported rotation after a resync marks a cycle slip in the demodulator.

A pulse marks every pass of the local generator through its all-ones state. This gives a repeating trigger at the period of the sequence. The pulse is held back for any period that carried too many errors.

Top module: `ber_prbs11_monitor`

## Requirements
- R1: After reset, sync_ok, phase_code, stream_inverted, err_count and seq_start are all zero.
- R2: With qpsk_mode low, each strobe carries one bit, in sym_bits[0], and sym_bits[1] is ignored. With qpsk_mode high, each strobe carries two bits, and sym_bits[1] is the earlier of the two in the sequence.
- R3: While searching, the first 11 bits received under a hypothesis only load the history. A later bit that breaks the recurrence b[n] = b[n-11] xor b[n-9] rejects the hypothesis, and that bit is not used. sync_ok rises after SYNC_RUN (64) consecutive matching bits. A clean single-bit stream with the right hypothesis sets sync_ok after its 75th strobe, and not after its 74th.
- R4: While in sync, the local generator runs on its own state, so each wrong received bit adds exactly one error.
- R5: A window is WIN_BITS bits in sync, starting with the first strobe after sync rises. err_count takes the window's error total once, at the strobe that completes the window, and holds it through later windows, through loss of sync and through idle time.
- R6: In single-bit mode, two hypotheses are tried: phase_code 00 (as received) and then 10 (inverted). stream_inverted is 1 exactly when phase_code is 10.
- R7: In two-bit mode, the symbol {sym_bits[1], sym_bits[0]} has a Gray position: 00=0, 01=1, 11=2, 10=3. A rotation of k quarter turns adds k (mod 4) to that position. The hypotheses are tried in the order 0, 1, 2, 3, then 0 again. The locked hypothesis is reported as phase_code = k and does not change while in sync.
- R8: In sync, bits are grouped into blocks of BLK_BITS (256). If a block ends holding more than BLK_LIMIT (64) errors, sync_ok falls after that strobe. The window and block counts restart, and the search resumes from the current hypothesis.
- R9: seq_start pulses for one cycle after a strobe in which the in-sync generator reached its all-ones state, provided fewer than 205 errors arrived since the previous such point or since sync was gained. The pulse is withheld in the strobe that loses sync.
- R10: A cycle with sym_valid low changes none of the outputs except clearing seq_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qpsk_mode | input | 1 | 0: one bit per strobe; 1: two-bit symbol per strobe (held static between resets) |
| sym_valid | input | 1 | Strobe: sym_bits holds a new symbol |
| sym_bits | input | 2 | Demodulated symbol bits |
| sync_ok | output | 1 | 1 while locked to the sequence |
| phase_code | output | 2 | Rotation hypothesis in use, in quarter turns |
| stream_inverted | output | 1 | Locked hypothesis is a half turn (inverted stream) |
| err_count | output | 32 | Error total of the last completed window |
| seq_start | output | 1 | One-cycle pulse at each clean sequence start |

## Verification
A wrong hypothesis or a bad history load shows up as a late sync_ok or a wrong phase_code. This appears within a few dozen strobes of a clean stream, or after an induced inversion or rotation. A generator that drifts, or one that resyncs from received data, multiplies every injected error. err_count then misses its exact expected total at the first window boundary. Block and period counting mistakes shift the strobe at which sync_ok falls or seq_start fires. The bench compares both outputs against a bit-accurate arithmetic model on every strobe.

// File: rtl/ber_pkg.sv
package ber_pkg;
    localparam int unsigned PN_ORDER = 11;
    localparam int unsigned PN_TAP   = 9;
    localparam logic [PN_ORDER-1:0] PN_MARK = '1;

    typedef logic [1:0] phase_t;

    typedef struct packed {
        logic [PN_ORDER-1:0] hist;
        logic [3:0]          fill;
        logic [7:0]          run;
        phase_t              hyp;
        logic                locked;
        logic [11:0]         per_err;
        logic                start;
    } trk_t;

    // Next rotation to try: quarter steps for symbols, half step for bits
    function automatic phase_t next_hyp(phase_t h, logic qpsk);
        return qpsk ? phase_t'(h + 2'd1) : {~h[1], 1'b0};
    endfunction
endpackage

// File: rtl/ber_derotate.sv
module ber_derotate
    import ber_pkg::*;
(
    input  logic [1:0] sym,
    input  phase_t     hyp,
    input  logic       qpsk,
    output logic [1:0] seq_bits   // [0] earlier in sequence, [1] later
);
    logic a_in, b_in;

    always_comb begin
        a_in     = sym[1];
        b_in     = sym[0];
        seq_bits = 2'b00;
        if (!qpsk) begin
            seq_bits[0] = sym[0] ^ hyp[1];
        end else begin
            unique case (hyp)
                2'd0: seq_bits = {b_in, a_in};
                2'd1: seq_bits = {a_in, ~b_in};
                2'd2: seq_bits = {~b_in, ~a_in};
                default: seq_bits = {~a_in, b_in};
            endcase
        end
    end
endmodule

// File: rtl/ber_track.sv
module ber_track
    import ber_pkg::*;
#(
    parameter int unsigned SYNC_RUN    = 64,
    parameter int unsigned START_LIMIT = 205
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       qpsk,
    input  logic [1:0] rx_bits,
    input  logic       drop,
    output phase_t     hyp,
    output logic       locked,
    output logic       start,
    output logic [1:0] chk_cnt,
    output logic [1:0] chk_err
);
    localparam logic [3:0]  FILL_FULL = 4'(PN_ORDER);
    localparam logic [7:0]  RUN_GOAL  = 8'(SYNC_RUN);
    localparam logic [11:0] PER_LIM   = 12'(START_LIMIT);

    trk_t q, d;
    logic pred, abort;
    int   nb;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        chk_cnt = 2'd0;
        chk_err = 2'b00;
        abort   = 1'b0;
        pred    = 1'b0;
        nb      = qpsk ? 2 : 1;
        if (in_valid) begin
            for (int i = 0; i < 2; i++) begin
                if (i < nb && !abort) begin
                    pred = d.hist[PN_ORDER-1] ^ d.hist[PN_TAP-1];
                    if (q.locked) begin
                        chk_err[i] = rx_bits[i] ^ pred;
                        chk_cnt    = chk_cnt + 2'd1;
                        d.hist     = {d.hist[PN_ORDER-2:0], pred};
                        d.per_err  = d.per_err + {11'd0, chk_err[i]};
                        if (d.hist == PN_MARK) begin
                            if (d.per_err < PER_LIM) d.start = 1'b1;
                            d.per_err = '0;
                        end
                    end else if (d.fill < FILL_FULL) begin
                        d.hist = {d.hist[PN_ORDER-2:0], rx_bits[i]};
                        d.fill = d.fill + 4'd1;
                    end else if (rx_bits[i] == pred) begin
                        d.hist = {d.hist[PN_ORDER-2:0], rx_bits[i]};
                        if (d.run < RUN_GOAL) d.run = d.run + 8'd1;
                    end else begin
                        d.hyp  = next_hyp(d.hyp, qpsk);
                        d.fill = '0;
                        d.run  = '0;
                        abort  = 1'b1;
                    end
                end
            end
            if (!q.locked && d.run >= RUN_GOAL) begin
                d.locked  = 1'b1;
                d.run     = '0;
                d.per_err = '0;
            end
        end
        if (drop) begin
            d.locked  = 1'b0;
            d.fill    = '0;
            d.run     = '0;
            d.per_err = '0;
            d.start   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hyp    = q.hyp;
    assign locked = q.locked;
    assign start  = q.start;

    AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.locked && !in_valid) |=> !q.locked); // R3
    AST_HYP_HELD_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked |=> $stable(q.hyp)); // R7
    AST_START_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> q.locked); // R9
endmodule

// File: rtl/ber_tally.sv
module ber_tally #(
    parameter int unsigned WIN_BITS  = 1000000,
    parameter int unsigned BLK_BITS  = 256,
    parameter int unsigned BLK_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic [1:0]  chk_cnt,
    input  logic [1:0]  chk_err,
    output logic        drop,
    output logic [31:0] count
);
    localparam int unsigned WIN_W = $clog2(WIN_BITS + 1);
    localparam int unsigned BLK_W = $clog2(BLK_BITS + 1);
    localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_BITS);
    localparam logic [BLK_W-1:0] BLK_END = BLK_W'(BLK_BITS);
    localparam logic [BLK_W-1:0] BLK_LIM = BLK_W'(BLK_LIMIT);

    typedef struct packed {
        logic [WIN_W-1:0] win_cnt;
        logic [31:0]      win_err;
        logic [BLK_W-1:0] blk_cnt;
        logic [BLK_W-1:0] blk_err;
        logic [31:0]      count;
    } tally_t;

    tally_t q, d;

    always_comb begin
        d    = q;
        drop = 1'b0;
        if (active) begin
            for (int i = 0; i < 2; i++) begin
                if (i < int'(chk_cnt)) begin
                    d.win_err = d.win_err + 32'(chk_err[i]);
                    d.win_cnt = d.win_cnt + 1'b1;
                    if (d.win_cnt == WIN_END) begin
                        d.count   = d.win_err;
                        d.win_cnt = '0;
                        d.win_err = '0;
                    end
                    d.blk_err = d.blk_err + BLK_W'(chk_err[i]);
                    d.blk_cnt = d.blk_cnt + 1'b1;
                    if (d.blk_cnt == BLK_END) begin
                        if (d.blk_err > BLK_LIM) drop = 1'b1;
                        d.blk_cnt = '0;
                        d.blk_err = '0;
                    end
                end
            end
        end
        if (!active || drop) begin
            d.win_cnt = '0;
            d.win_err = '0;
            d.blk_cnt = '0;
            d.blk_err = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.count;

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_cnt == 2'd0) |=> $stable(q.count)); // R5
    AST_WIN_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.win_err <= 32'(q.win_cnt)); // R4
    AST_RESTART_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (q.win_cnt == '0 && q.blk_cnt == '0)); // R8
endmodule

// File: rtl/ber_prbs11_monitor.sv
module ber_prbs11_monitor
    import ber_pkg::*;
#(
    parameter int unsigned WIN_BITS    = 1000000,
    parameter int unsigned SYNC_RUN    = 64,
    parameter int unsigned BLK_BITS    = 256,
    parameter int unsigned BLK_LIMIT   = 64,
    parameter int unsigned START_LIMIT = 205
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        qpsk_mode,
    input  logic        sym_valid,
    input  logic [1:0]  sym_bits,
    output logic        sync_ok,
    output logic [1:0]  phase_code,
    output logic        stream_inverted,
    output logic [31:0] err_count,
    output logic        seq_start
);
    phase_t     hyp;
    logic [1:0] rx_bits;
    logic [1:0] chk_cnt;
    logic [1:0] chk_err;
    logic       locked;
    logic       drop;

    ber_derotate u_derot (
        .sym      (sym_bits),
        .hyp      (hyp),
        .qpsk     (qpsk_mode),
        .seq_bits (rx_bits)
    );

    ber_track #(
        .SYNC_RUN    (SYNC_RUN),
        .START_LIMIT (START_LIMIT)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (sym_valid),
        .qpsk     (qpsk_mode),
        .rx_bits  (rx_bits),
        .drop     (drop),
        .hyp      (hyp),
        .locked   (locked),
        .start    (seq_start),
        .chk_cnt  (chk_cnt),
        .chk_err  (chk_err)
    );

    ber_tally #(
        .WIN_BITS  (WIN_BITS),
        .BLK_BITS  (BLK_BITS),
        .BLK_LIMIT (BLK_LIMIT)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (locked),
        .chk_cnt (chk_cnt),
        .chk_err (chk_err),
        .drop    (drop),
        .count   (err_count)
    );

    assign sync_ok         = locked;
    assign phase_code      = hyp;
    assign stream_inverted = (hyp == 2'b10);
endmodule

// File: tb/tb_ber_prbs11_monitor.sv
`timescale 1ns/1ps
module tb_ber_prbs11_monitor;
    localparam int W = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        qpsk_mode = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_bits = 2'b00;
    logic        sync_ok;
    logic [1:0]  phase_code;
    logic        stream_inverted;
    logic [31:0] err_count;
    logic        seq_start;

    always #2.5 clk = ~clk;

    ber_prbs11_monitor #(.WIN_BITS(W)) dut (
        .clk(clk), .rst_n(rst_n), .qpsk_mode(qpsk_mode), .sym_valid(sym_valid),
        .sym_bits(sym_bits), .sync_ok(sync_ok), .phase_code(phase_code),
        .stream_inverted(stream_inverted), .err_count(err_count), .seq_start(seq_start)
    );

    int n_run = 0, n_fail = 0;
    logic [10:0] pn;
    // arithmetic model state
    bit m_sync; int m_hyp; int m_wcnt, m_werr, m_bcnt, m_berr, m_perr;
    int m_count; int n_supp, n_pulse, n_drop;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; sym_valid = 1'b0; qpsk_mode = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_sync = 0; m_hyp = 0; m_wcnt = 0; m_werr = 0; m_bcnt = 0; m_berr = 0;
        m_perr = 0; m_count = 0;
        chk("R1 sync_ok", 32'(sync_ok), 0);
        chk("R1 phase_code", 32'(phase_code), 0);
        chk("R1 inverted", 32'(stream_inverted), 0);
        chk("R1 err_count", err_count, 0);
        chk("R1 seq_start", 32'(seq_start), 0);
    endtask

    task automatic strobe(input int rot, input logic [1:0] flip);
        logic [1:0] tx, mk, rx, dr, pos, dpos;
        logic b, s_sync; logic [31:0] s_cnt; logic [1:0] s_ph;
        int nb; bit drop, st;
        tx = 0; mk = 0; dr = 0; drop = 0; st = 0;
        if ($urandom_range(0, 4) == 0) begin
            s_sync = sync_ok; s_cnt = err_count; s_ph = phase_code;
            sym_valid = 1'b0; sym_bits = 2'($urandom);
            @(negedge clk);
            chk("R10 idle sync", 32'(sync_ok), 32'(s_sync));
            chk("R10 idle count", err_count, s_cnt);
            chk("R10 idle phase", 32'(phase_code), 32'(s_ph));
        end
        nb = qpsk_mode ? 2 : 1;
        for (int i = 0; i < nb; i++) begin
            b = pn[10] ^ pn[8];
            pn = {pn[9:0], b};
            tx[i] = b;
            mk[i] = (pn == 11'h7FF);
        end
        rx = tx ^ flip;
        if (!qpsk_mode) begin
            sym_bits = {1'($urandom), rx[0] ^ (rot == 2)};
            dr[0] = sym_bits[0] ^ (m_hyp == 2);
        end else begin
            pos = {rx[0], rx[0] ^ rx[1]} + 2'(rot);
            sym_bits = {pos[1], pos[1] ^ pos[0]};
            dpos = pos - 2'(m_hyp);
            dr[0] = dpos[1];
            dr[1] = dpos[1] ^ dpos[0];
        end
        sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        if (m_sync) begin
            for (int i = 0; i < nb; i++) begin
                int e;
                e = int'(dr[i] ^ tx[i]);
                m_werr += e; m_wcnt++;
                if (m_wcnt == W) begin m_count = m_werr; m_wcnt = 0; m_werr = 0; end
                m_berr += e; m_bcnt++;
                if (m_bcnt == 256) begin
                    if (m_berr > 64) drop = 1;
                    m_bcnt = 0; m_berr = 0;
                end
                m_perr += e;
                if (mk[i]) begin
                    if (m_perr < 205) st = 1; else n_supp++;
                    m_perr = 0;
                end
            end
            if (drop) st = 0;
            if (seq_start) n_pulse++;
            chk("R8 sync held or dropped", 32'(sync_ok), 32'(!drop));
            chk("R4 R5 window count", err_count, 32'(m_count));
            chk("R9 seq_start", 32'(seq_start), 32'(st));
            if (drop) begin
                n_drop++; m_sync = 0;
                m_wcnt = 0; m_werr = 0; m_bcnt = 0; m_berr = 0;
            end
        end else begin
            chk("R9 no start out of sync", 32'(seq_start), 0);
            chk("R5 count kept", err_count, 32'(m_count));
            if (sync_ok) begin
                chk("R6 R7 phase at lock", 32'(phase_code), 32'(rot));
                chk("R6 inverted at lock", 32'(stream_inverted), 32'(rot == 2));
                m_sync = 1; m_hyp = rot;
                m_wcnt = 0; m_werr = 0; m_bcnt = 0; m_berr = 0; m_perr = 0;
            end
        end
    endtask

    bit done = 0;
    initial begin
        #750000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        n_supp = 0; n_pulse = 0; n_drop = 0;
        // Single-bit mode: clean lock, error windows, heavy-error period, inversion slip
        pn = 11'h5A5;
        do_reset(1'b0);
        for (int s = 1; s <= 9800; s++) begin
            int rot; logic [1:0] fl;
            rot = (s >= 9000) ? 2 : 0;
            fl = 2'b00;
            if (m_sync && (s == 100 || s == 500 || s == 1500 || s == 2100 ||
                (s >= 4200 && s < 8300 && s % 8 == 0))) fl = 2'b01;
            strobe(rot, fl);
            if (s == 74)   chk("R3 R2 no sync before 75 strobes", 32'(sync_ok), 0);
            if (s == 75)   chk("R3 sync after 75 strobes", 32'(sync_ok), 1);
            if (s == 2074) chk("R5 count before first window end", err_count, 0);
            if (s == 2075) chk("R4 three single errors", err_count, 3);
            if (s == 3000) chk("R5 count held", err_count, 3);
            if (s == 4075) chk("R4 R5 second window", err_count, 1);
        end
        chk("R8 inversion caused a drop", 32'(n_drop > 0), 1);
        chk("R6 relocked inverted", 32'(sync_ok), 1);
        chk("R6 phase 10", 32'(phase_code), 2);
        chk("R6 inverted flag", 32'(stream_inverted), 1);
        chk("R9 pulses seen", 32'(n_pulse > 0), 1);
        chk("R9 a start was suppressed", 32'(n_supp > 0), 1);

        // Two-bit mode: three quarter turns, then slip to one quarter turn
        pn = 11'h0F3; n_drop = 0;
        do_reset(1'b1);
        for (int s = 1; s <= 6000; s++) begin
            logic [1:0] fl;
            fl = 2'b00;
            if (m_sync) fl = {(s % 131 == 0), (s % 97 == 0)};
            strobe((s < 3000) ? 3 : 1, fl);
            if (s == 2999) begin
                chk("R7 locked at three quarter turns", 32'(sync_ok), 1);
                chk("R7 phase 3", 32'(phase_code), 3);
            end
        end
        chk("R8 rotation slip caused a drop", 32'(n_drop > 0), 1);
        chk("R7 relocked", 32'(sync_ok), 1);
        chk("R7 phase 1", 32'(phase_code), 1);
        chk("R7 not inverted", 32'(stream_inverted), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule